// File: doc/BRIEF.md
# Dual Time Base Generator

This block produces two free-running count values that timer channels across a chip use as common references. Counter A normally advances once per period of its own prescaler. That prescaler divides the system clock by an even ratio between 2 and 512. Counter A can instead follow the terminal pulses of counter B's prescaler. Counter B advances on its own prescaler in time mode. In angle mode it counts rising edges of an external tick input, so channels can work in angle rather than in time.

All state lives in the system-clock domain. No derived clocks are made: each counter moves on a single-cycle enable pulse. Both values are exported on output buses and can be read through a small read-address port. A global run enable freezes both counters and both prescalers. A synchronous clear returns all of them to zero.

Top module: `dual_timebase`

## Requirements
- R1: After reset, both counters, both prescalers and the tick history are zero, so `tbAOut`, `tbBOut` and `rdData` read 0.
- R2: With `srcSelA`=0, after k enabled cycles since the last clear, `tbAOut` equals floor(k / (2*(divSelA+1))) modulo 2^CNT_W. For example, `divSelA`=0 divides by 2 and `divSelA`=255 divides by 512.
- R3: With `srcSelA`=1, counter A advances on counter B's prescaler pulse, so `tbAOut` equals floor(k / (divSelB+1)) modulo 2^CNT_W. This holds whatever the value of `divSelA`.
- R4: With `angleModeB`=0, `tbBOut` equals floor(k / (divSelB+1)) modulo 2^CNT_W, and `angleTick` has no effect on it.
- R5: With `angleModeB`=1, counter B increments once in each enabled cycle where `angleTick` is 1 and was 0 in the previous cycle. Counter B's prescaler has no effect on counter B in this mode.
- R6: While `runEn`=0, both counters and both prescalers hold their values, and tick edges that occur in that time are not counted.
- R7: When `syncClr`=1 at a clock edge, both counters and both prescalers are zero after that edge, whatever the value of `runEn`.
- R8: A counter holding the all-ones value wraps to 0 on its next increment and keeps counting.
- R9: `rdData` is combinational: address 0 returns counter A, address 1 returns counter B, and addresses 2 and 3 return 0.
- R10: `tbAOut` and `tbBOut` always carry the present counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Global enable for both counters and both prescalers |
| syncClr | input | 1 | Synchronous clear of both counters and both prescalers |
| divSelA | input | DIV_W | Counter A divide setting N, ratio 2*(N+1) |
| divSelB | input | DIV_W | Counter B divide setting N, ratio N+1 |
| srcSelA | input | 1 | 0: counter A uses its own prescaler; 1: counter A uses B's prescaler pulse |
| angleModeB | input | 1 | 1: counter B counts angle tick edges |
| angleTick | input | 1 | External angle tick, synchronous to clk |
| rdAddr | input | 2 | Register read address |
| rdData | output | CNT_W | Read data for rdAddr |
| tbAOut | output | CNT_W | Exported counter A value |
| tbBOut | output | CNT_W | Exported counter B value |

## Verification
The assertions assume that `angleTick` is already synchronous to `clk` and is stable around the edge. They also assume that the divide settings only change together with a clear, so that a counter moves by at most one step per cycle. The bench drives all inputs on the falling edge. It changes `divSelA`, `divSelB`, `srcSelA` and `angleModeB` only around a `syncClr` pulse. It shapes tick pulses of one to three cycles high and one to three cycles low, so each intended rising edge is seen exactly once. The bench uses a 10-bit counter width so that wrap-around is reached within a short run.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  // Strobes sent from the control module to the counter datapath
  typedef struct packed {
    logic clr;
    logic incA;
    logic incB;
  } tbStrobe_t;

  localparam int NUM_LANES = 2;
  localparam int LANE_A    = 0;
  localparam int LANE_B    = 1;

  // Read address map
  localparam logic [1:0] RD_ADDR_A = 2'd0;
  localparam logic [1:0] RD_ADDR_B = 2'd1;

endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             syncClr,
  input  logic [DIV_W-1:0] divSelA,
  input  logic [DIV_W-1:0] divSelB,
  input  logic             srcSelA,
  input  logic             angleModeB,
  input  logic             angleTick,
  output tbStrobe_t        strobe
);

  localparam int PRE_A_W = DIV_W + 1;

  logic [PRE_A_W-1:0] preA;
  logic [DIV_W-1:0]   preB;
  logic [PRE_A_W-1:0] limitA;
  logic               termA;
  logic               termB;
  logic               tickPrev;
  logic               tickRise;
  logic               advance;

  // Prescaler A terminal count is 2N+1, which gives a ratio of 2*(N+1)
  assign limitA   = {divSelA, 1'b1};
  assign termA    = (preA >= limitA);
  assign termB    = (preB >= divSelB);
  assign tickRise = angleTick & ~tickPrev;
  assign advance  = runEn & ~syncClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preA <= '0;
      preB <= '0;
    end else if (syncClr) begin
      preA <= '0;
      preB <= '0;
    end else if (runEn) begin
      preA <= termA ? '0 : preA + 1'b1;
      preB <= termB ? '0 : preB + 1'b1;
    end
  end

  // The tick history follows the pin in every cycle, so edges seen while
  // the block is disabled are dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickPrev <= 1'b0;
    else       tickPrev <= angleTick;
  end

  always_comb begin
    strobe.clr  = syncClr;
    strobe.incA = advance & (srcSelA ? termB : termA);
    strobe.incB = advance & (angleModeB ? tickRise : termB);
  end

endmodule

// File: rtl/timebase_dp.sv
module timebase_dp
  import timebase_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strobe,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] cntA,
  output logic [CNT_W-1:0] cntB,
  output logic [CNT_W-1:0] rdData
);

  logic [CNT_W-1:0]     cnt [NUM_LANES];
  logic [NUM_LANES-1:0] incVec;

  assign incVec[LANE_A] = strobe.incA;
  assign incVec[LANE_B] = strobe.incB;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cnt[i] <= '0;
      else if (strobe.clr) cnt[i] <= '0;
      else if (incVec[i])  cnt[i] <= cnt[i] + 1'b1;
    end
  end

  assign cntA = cnt[LANE_A];
  assign cntB = cnt[LANE_B];

  always_comb begin
    case (rdAddr)
      RD_ADDR_A: rdData = cnt[LANE_A];
      RD_ADDR_B: rdData = cnt[LANE_B];
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
  import timebase_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             syncClr,
  input  logic [DIV_W-1:0] divSelA,
  input  logic [DIV_W-1:0] divSelB,
  input  logic             srcSelA,
  input  logic             angleModeB,
  input  logic             angleTick,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] tbAOut,
  output logic [CNT_W-1:0] tbBOut
);

  tbStrobe_t strobe;

  timebase_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .syncClr    (syncClr),
    .divSelA    (divSelA),
    .divSelB    (divSelB),
    .srcSelA    (srcSelA),
    .angleModeB (angleModeB),
    .angleTick  (angleTick),
    .strobe     (strobe)
  );

  timebase_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdAddr (rdAddr),
    .cntA   (tbAOut),
    .cntB   (tbBOut),
    .rdData (rdData)
  );

endmodule

// File: rtl/timebase_chk.sv
module timebase_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             syncClr,
  input logic             angleModeB,
  input logic             angleTick,
  input logic [1:0]       rdAddr,
  input logic [CNT_W-1:0] rdData,
  input logic [CNT_W-1:0] tbAOut,
  input logic [CNT_W-1:0] tbBOut
);

  AST_A_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !syncClr |=> (tbAOut == $past(tbAOut)) || (tbAOut == CNT_W'($past(tbAOut) + 1'b1))); // R2

  AST_B_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !syncClr |=> (tbBOut == $past(tbBOut)) || (tbBOut == CNT_W'($past(tbBOut) + 1'b1))); // R8

  AST_ANGLE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (angleModeB && !angleTick && !syncClr) |=> $stable(tbBOut)); // R5

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !syncClr) |=> ($stable(tbAOut) && $stable(tbBOut))); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    syncClr |=> (tbAOut == '0 && tbBOut == '0)); // R7

  AST_READ_A: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 2'd0) |-> (rdData == tbAOut)); // R9

  AST_READ_B: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 2'd1) |-> (rdData == tbBOut)); // R9

  AST_READ_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr[1] |-> (rdData == '0)); // R9

endmodule

bind dual_timebase timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .runEn      (runEn),
  .syncClr    (syncClr),
  .angleModeB (angleModeB),
  .angleTick  (angleTick),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .tbAOut     (tbAOut),
  .tbBOut     (tbBOut)
);

// File: tb/dual_timebase_test.sv
module dual_timebase_test;

  localparam int CW  = 10;
  localparam int DW  = 8;
  localparam int MOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runEn = 1'b0;
  logic          syncClr = 1'b0;
  logic [DW-1:0] divSelA = '0;
  logic [DW-1:0] divSelB = '0;
  logic          srcSelA = 1'b0;
  logic          angleModeB = 1'b0;
  logic          angleTick = 1'b0;
  logic [1:0]    rdAddr = 2'd0;
  logic [CW-1:0] rdData;
  logic [CW-1:0] tbAOut;
  logic [CW-1:0] tbBOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dual_timebase #(.CNT_W(CW), .DIV_W(DW)) uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .syncClr(syncClr),
    .divSelA(divSelA), .divSelB(divSelB), .srcSelA(srcSelA),
    .angleModeB(angleModeB), .angleTick(angleTick), .rdAddr(rdAddr),
    .rdData(rdData), .tbAOut(tbAOut), .tbBOut(tbBOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clearAll();
    runEn = 1'b0;
    syncClr = 1'b1;
    cyc(1);
    syncClr = 1'b0;
  endtask

  task automatic readAt(input logic [1:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1: reset state
    chk("R1 A after reset", int'(tbAOut), 0);
    chk("R1 B after reset", int'(tbBOut), 0);
    readAt(2'd0, v); chk("R1 read A after reset", v, 0);

    // R2 R4 R10: sweep the divide settings, with ticks ignored in time mode
    for (int na = 0; na < 16; na++) begin
      int nb = (na * 3) % 8;
      int k  = 100 + na * 7;
      divSelA = DW'(na); divSelB = DW'(nb); srcSelA = 1'b0; angleModeB = 1'b0;
      clearAll();
      runEn = 1'b1;
      for (int c = 0; c < k; c++) begin
        angleTick = c[0];
        cyc(1);
      end
      runEn = 1'b0; angleTick = 1'b0;
      chk("R2 A prescaled", int'(tbAOut), (k / (2 * (na + 1))) % MOD);
      chk("R4 B prescaled, ticks ignored", int'(tbBOut), (k / (nb + 1)) % MOD);
      readAt(2'd0, v); chk("R10 export A equals read", v, int'(tbAOut));
      readAt(2'd1, v); chk("R10 export B equals read", v, int'(tbBOut));
    end

    // R2: largest ratio (512)
    divSelA = 8'd255; clearAll(); runEn = 1'b1; cyc(1500); runEn = 1'b0;
    chk("R2 A ratio 512", int'(tbAOut), 1500 / 512);

    // R3: A chained to the B prescaler pulse
    for (int nb = 0; nb < 8; nb++) begin
      divSelA = 8'd200; divSelB = DW'(nb); srcSelA = 1'b1; angleModeB = 1'b0;
      clearAll(); runEn = 1'b1; cyc(97); runEn = 1'b0;
      chk("R3 A chained to B prescaler", int'(tbAOut), 97 / (nb + 1));
    end
    srcSelA = 1'b0;

    // R5: angle mode with different pulse shapes
    for (int h = 1; h <= 3; h++) begin
      for (int l = 1; l <= 3; l++) begin
        divSelA = 8'd1; divSelB = 8'd0; angleModeB = 1'b1; angleTick = 1'b0;
        clearAll(); runEn = 1'b1;
        for (int p = 0; p < 6; p++) begin
          angleTick = 1'b1; cyc(h);
          angleTick = 1'b0; cyc(l);
        end
        runEn = 1'b0;
        chk("R5 B counts tick edges", int'(tbBOut), 6);
        chk("R5 A still prescaled", int'(tbAOut), (6 * (h + l)) / 4);
      end
    end

    // R6: hold while disabled (time mode)
    angleModeB = 1'b0; divSelA = 8'd2; divSelB = 8'd4;
    clearAll(); runEn = 1'b1; cyc(30); runEn = 1'b0;
    for (int c = 0; c < 20; c++) begin angleTick = c[0]; cyc(1); end
    angleTick = 1'b0;
    chk("R6 A holds when disabled", int'(tbAOut), 30 / 6);
    chk("R6 B holds when disabled", int'(tbBOut), 30 / 5);
    runEn = 1'b1; cyc(40); runEn = 1'b0;
    chk("R6 A resumes with prescaler state kept", int'(tbAOut), 70 / 6);
    chk("R6 B resumes with prescaler state kept", int'(tbBOut), 70 / 5);

    // R6: angle edges ignored while disabled
    angleModeB = 1'b1; clearAll(); runEn = 1'b1;
    for (int p = 0; p < 3; p++) begin angleTick = 1'b1; cyc(1); angleTick = 1'b0; cyc(1); end
    runEn = 1'b0;
    for (int p = 0; p < 4; p++) begin angleTick = 1'b1; cyc(1); angleTick = 1'b0; cyc(1); end
    chk("R6 angle edges ignored when disabled", int'(tbBOut), 3);
    runEn = 1'b1;
    for (int p = 0; p < 2; p++) begin angleTick = 1'b1; cyc(1); angleTick = 1'b0; cyc(1); end
    runEn = 1'b0;
    chk("R6 angle counting resumes", int'(tbBOut), 5);

    // R7: clear with runEn low
    angleModeB = 1'b0; runEn = 1'b1; cyc(25); runEn = 1'b0;
    clearAll();
    chk("R7 A cleared with runEn low", int'(tbAOut), 0);
    chk("R7 B cleared with runEn low", int'(tbBOut), 0);

    // R8: wrap-around at the counter width
    divSelA = 8'd0; divSelB = 8'd0;
    clearAll(); runEn = 1'b1; cyc(2 * MOD - 1); runEn = 1'b0;
    chk("R8 A at all-ones", int'(tbAOut), MOD - 1);
    runEn = 1'b1; cyc(1); runEn = 1'b0;
    chk("R8 A wraps to zero", int'(tbAOut), 0);
    chk("R8 B wrapped and kept counting", int'(tbBOut), (2 * MOD) % MOD);
    runEn = 1'b1; cyc(6); runEn = 1'b0;
    chk("R8 A counts after wrap", int'(tbAOut), 3);
    chk("R8 B counts after wrap", int'(tbBOut), 6);

    // R9: read map
    readAt(2'd0, v); chk("R9 read addr 0", v, 3);
    readAt(2'd1, v); chk("R9 read addr 1", v, 6);
    readAt(2'd2, v); chk("R9 read addr 2", v, 0);
    readAt(2'd3, v); chk("R9 read addr 3", v, 0);
    rdAddr = 2'd0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule